// File: doc/BRIEF.md
# Page-Confined Stride Stream Prefetcher

This block sits beside a cache and watches the demand line addresses that pass through it. It splits each address into a page number and a position within the page. A page holds 2^PAGE_BITS lines. A small, fully associative table holds one entry per page that is being tracked. For each entry it learns the distance between successive accesses. Once that distance repeats often enough, the block sends line addresses ahead of the demand stream to a prefetch queue. Each prefetch carries the source ID of the request that caused it.

Each entry keeps the following state:
- the two most recent positions accessed;
- the stride it currently believes in;
- a two-bit confidence counter;
- one bit per position, marking lines that have already been requested ahead of demand.

Prefetches never leave the page of the access that caused them. A line is never requested twice while its bit is still set. A new stride is adopted only when the same non-zero stride has been seen twice in a row while confidence is low. When a new page needs an entry, the least recently used entry is replaced. An entry that issued prefetches shortly before is protected from replacement.

Back-pressure rules:
- The request side never stalls: `req_ready` is high whenever reset is released.
- The prefetch side is a valid/ready queue. While `pf_valid` is high and `pf_ready` is low, the head item is held unchanged.
- When the queue has too few free slots for the prefetches an access would generate, the ones that do not fit are discarded. Their bits stay clear, so they can be generated again later.

Top module: `stride_stream_prefetcher`

## Requirements
- R1: A request is used for training only when `req_spec` is 0, `req_ifetch` is 0 and `req_kind` is 2'b00 (read for sharing) or 2'b01 (read for ownership). Kinds 2'b10 and 2'b11, speculative requests and instruction fetches change no table state and cause no prefetch.
- R2: The page of a request is `req_line >> PAGE_BITS`, and its position is the low PAGE_BITS bits. A prefetch's `pf_line` has the same page as the request that caused it, with the target position in the low bits. Its `pf_src` equals that request's `req_src`.
- R3: A newly allocated entry has stride 0 and confidence 0, and both of its stored positions equal the access position. The observed stride is the position minus the last position. While confidence is below 2, the stored stride is replaced by the observed stride, and confidence is cleared, only when the observed stride is non-zero, differs from the stored stride, and equals the last position minus the position before it. For a fresh page walked with stride +1 from position 0, the first prefetch comes on the fifth access.
- R4: Confidence is 2 bits and saturates at 0 and 3. It rises when the observed stride equals the stored stride and falls otherwise. When it is 2 or more after that update and the stride is non-zero, prefetches are generated. The first is at position + stride, and up to DEGREE−1 more follow at further stride steps. The chain stops at the first target that is unusable.
- R5: A target position below 0 or at or above 2^PAGE_BITS is never issued. This applies to both positive and negative strides.
- R6: Issuing a prefetch sets that position's bit. A training access to a position whose bit is set clears the bit. A target whose bit is set stops the chain.
- R7: Prefetches leave in the order they were generated. `pf_valid` and `pf_line`/`pf_src` hold steady while `pf_ready` is low. Prefetches that find the queue full are discarded with their bits left clear.
- R8: On a page miss, an empty entry is used first. Otherwise the candidate with the oldest last-touch time is replaced. No page is ever held by two entries.
- R9: An entry that issued prefetches within the last FILL_LAT − WARM_CYC cycles is not a replacement candidate. When there is no candidate, the request allocates nothing.
- R10: `req_ready` is 1 out of reset and the request side never applies back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Demand request present |
| req_ready | output | 1 | Request accepted (always 1 out of reset) |
| req_line | input | LINE_W | Demand line address |
| req_kind | input | 2 | Request kind: 00 read-shared, 01 read-exclusive, 10/11 other |
| req_spec | input | 1 | Request is speculative |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_src | input | SRC_W | Requesting source ID |
| pf_valid | output | 1 | Prefetch queue head valid |
| pf_ready | input | 1 | Consumer takes the head item |
| pf_line | output | LINE_W | Prefetch line address |
| pf_src | output | SRC_W | Source ID carried with the prefetch |

## Verification
The bench checks training timing on a unit-stride walk. A design that adopts a stride after a single sighting, or predicts at confidence 1, prefetches one access too early. It checks that the prefetch chain stops at an already-set bit, both inside and at the edges of the page and for a negative stride. A design without the stop repeats prefetches or crosses the page edge. It holds the prefetch queue full and then checks that the dropped targets come back. A design that marks dropped prefetches as issued stays silent where they should reappear. It also checks that replacement picks the oldest entry while skipping an entry that has just issued prefetches. Picking a fixed slot, or ignoring the protection, destroys a trained entry, and that entry's next prefetches never come.

// File: rtl/spf_pkg.sv
package spf_pkg;

  typedef enum logic [1:0] {
    KIND_RD_SHARED = 2'b00,
    KIND_RD_OWN    = 2'b01,
    KIND_WRITE     = 2'b10,
    KIND_MISC      = 2'b11
  } req_kind_e;

  localparam logic [1:0] CONF_TOP  = 2'd3;
  localparam logic [1:0] CONF_PRED = 2'd2;

  // Only non-speculative data reads train the table.
  function automatic logic trains(input logic [1:0] kind, input logic spec, input logic ifetch);
    return !spec && !ifetch &&
           (req_kind_e'(kind) == KIND_RD_SHARED || req_kind_e'(kind) == KIND_RD_OWN);
  endfunction

endpackage

// File: rtl/spf_stride_train.sv
module spf_stride_train
  import spf_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 6,
  parameter int unsigned DEGREE    = 2,
  parameter int unsigned CNT_W     = 4
) (
  input  logic [PAGE_BITS-1:0]              pos,
  input  logic [PAGE_BITS-1:0]              last_pos,
  input  logic [PAGE_BITS-1:0]              last2_pos,
  input  logic signed [PAGE_BITS:0]         stride,
  input  logic [1:0]                        conf,
  input  logic [(1<<PAGE_BITS)-1:0]         map,
  input  logic [CNT_W-1:0]                  free_slots,
  output logic signed [PAGE_BITS:0]         stride_next,
  output logic [1:0]                        conf_next,
  output logic [(1<<PAGE_BITS)-1:0]         map_next,
  output logic [CNT_W-1:0]                  pf_cnt,
  output logic [DEGREE-1:0][PAGE_BITS-1:0]  pf_pos
);
  localparam int unsigned SW = PAGE_BITS + 1;
  localparam int unsigned TW = PAGE_BITS + 2;

  logic signed [SW-1:0] seen;
  logic signed [SW-1:0] prior;
  logic signed [TW-1:0] step;
  logic signed [TW-1:0] cursor;
  logic                 chain;

  assign seen  = $signed({1'b0, pos})      - $signed({1'b0, last_pos});
  assign prior = $signed({1'b0, last_pos}) - $signed({1'b0, last2_pos});
  assign step  = $signed({stride[SW-1], stride});

  always_comb begin
    map_next      = map;
    map_next[pos] = 1'b0;
    stride_next   = stride;
    conf_next     = conf;
    pf_cnt        = '0;
    pf_pos        = '0;
    cursor        = $signed({2'b00, pos});
    chain         = 1'b1;

    if (seen == stride) begin
      if (conf != CONF_TOP) conf_next = conf + 2'd1;
    end else if (conf != 2'd0) begin
      conf_next = conf - 2'd1;
    end

    if (conf_next >= CONF_PRED) begin
      for (int k = 0; k < DEGREE; k++) begin
        cursor = cursor + step;
        // in page: sign bit and overflow bit both clear
        if (chain && stride != '0 && !cursor[TW-1] && !cursor[TW-2] &&
            !map_next[cursor[PAGE_BITS-1:0]] && pf_cnt < free_slots) begin
          map_next[cursor[PAGE_BITS-1:0]] = 1'b1;
          pf_pos[k] = cursor[PAGE_BITS-1:0];
          pf_cnt    = pf_cnt + CNT_W'(1);
        end else begin
          chain = 1'b0;
        end
      end
    end else if (seen != '0 && seen != stride && seen == prior) begin
      stride_next = seen;
      conf_next   = 2'd0;
    end
  end

endmodule

// File: rtl/spf_victim_sel.sv
module spf_victim_sel #(
  parameter int unsigned ENTRIES  = 8,
  parameter int unsigned TIME_W   = 32,
  parameter int unsigned WARM_CYC = 500,
  parameter int unsigned IW       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][TIME_W-1:0] ent_ts,
  input  logic [ENTRIES-1:0][TIME_W-1:0] ent_busy,
  input  logic [TIME_W-1:0]              now,
  output logic                           found,
  output logic [IW-1:0]                  victim
);
  logic              have_empty;
  logic [TIME_W-1:0] age;
  logic [TIME_W-1:0] ahead;
  logic [TIME_W-1:0] best_age;

  always_comb begin
    found      = 1'b0;
    victim     = '0;
    have_empty = 1'b0;
    age        = '0;
    ahead      = '0;
    best_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!ent_valid[i] && !have_empty) begin
        have_empty = 1'b1;
        found      = 1'b1;
        victim     = IW'(i);
      end
    end
    if (!have_empty) begin
      for (int i = 0; i < ENTRIES; i++) begin
        age   = now - ent_ts[i];
        ahead = ent_busy[i] - now;
        if (!($signed(ahead) > $signed(TIME_W'(WARM_CYC))) && (!found || age > best_age)) begin
          found    = 1'b1;
          victim   = IW'(i);
          best_age = age;
        end
      end
    end
  end

endmodule

// File: rtl/spf_pf_fifo.sv
module spf_pf_fifo #(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned W        = 40,
  parameter int unsigned PUSH_MAX = 2,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CNT_W-1:0]             push_cnt,
  input  logic [PUSH_MAX-1:0][W-1:0]   push_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [W-1:0]                 out_data,
  output logic [CNT_W-1:0]             free_slots
);
  localparam int unsigned PW = $clog2(DEPTH);

  logic [W-1:0]     slots [DEPTH];
  logic [PW-1:0]    rd_ptr;
  logic [PW-1:0]    wr_ptr;
  logic [CNT_W-1:0] count;
  logic             pop;

  assign out_valid  = count != '0;
  assign out_data   = slots[rd_ptr];
  assign pop        = out_valid && out_ready;
  assign free_slots = CNT_W'(DEPTH) - count;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_MAX; k++) begin
      if (CNT_W'(k) < push_cnt) slots[wr_ptr + PW'(k)] <= push_data[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(push_cnt);
      rd_ptr <= rd_ptr + PW'(pop);
      count  <= count + push_cnt - CNT_W'(pop);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/stride_stream_prefetcher.sv
module stride_stream_prefetcher
  import spf_pkg::*;
#(
  parameter int unsigned LINE_W     = 32,
  parameter int unsigned PAGE_BITS  = 6,
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned DEGREE     = 2,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned SRC_W      = 4,
  parameter int unsigned TIME_W     = 32,
  parameter int unsigned WARM_CYC   = 500,
  parameter int unsigned FILL_LAT   = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LINE_W-1:0] req_line,
  input  logic [1:0]        req_kind,
  input  logic              req_spec,
  input  logic              req_ifetch,
  input  logic [SRC_W-1:0]  req_src,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line,
  output logic [SRC_W-1:0]  pf_src
);
  localparam int unsigned LINES  = 1 << PAGE_BITS;
  localparam int unsigned PAGE_W = LINE_W - PAGE_BITS;
  localparam int unsigned SW     = PAGE_BITS + 1;
  localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned QW     = SRC_W + LINE_W;

  // table state
  logic [ENTRIES-1:0]                ent_valid;
  logic [ENTRIES-1:0][PAGE_W-1:0]    ent_page;
  logic [ENTRIES-1:0][PAGE_BITS-1:0] ent_last;
  logic [ENTRIES-1:0][PAGE_BITS-1:0] ent_last2;
  logic [ENTRIES-1:0][SW-1:0]        ent_stride;
  logic [ENTRIES-1:0][1:0]           ent_conf;
  logic [ENTRIES-1:0][LINES-1:0]     ent_map;
  logic [ENTRIES-1:0][TIME_W-1:0]    ent_ts;
  logic [ENTRIES-1:0][TIME_W-1:0]    ent_busy;
  logic [TIME_W-1:0]                 now;

  logic                 req_fire;
  logic                 learn;
  logic [PAGE_W-1:0]    req_page;
  logic [PAGE_BITS-1:0] req_pos;
  logic [ENTRIES-1:0]   hit_vec;
  logic                 hit_any;
  logic [IW-1:0]        hit_idx;
  logic                 vic_found;
  logic [IW-1:0]        vic_idx;
  logic                 do_train;
  logic                 do_alloc;
  logic [TIME_W-1:0]    fill_time;

  logic signed [SW-1:0]              tr_stride;
  logic [1:0]                        tr_conf;
  logic [LINES-1:0]                  tr_map;
  logic [CNT_W-1:0]                  tr_cnt;
  logic [DEGREE-1:0][PAGE_BITS-1:0]  tr_pos;
  logic [CNT_W-1:0]                  free_slots;
  logic [CNT_W-1:0]                  push_cnt;
  logic [DEGREE-1:0][QW-1:0]         push_data;
  logic [QW-1:0]                     head;

  assign req_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;
  assign learn     = req_fire && trains(req_kind, req_spec, req_ifetch);
  assign req_page  = req_line[LINE_W-1:PAGE_BITS];
  assign req_pos   = req_line[PAGE_BITS-1:0];
  assign fill_time = now + TIME_W'(FILL_LAT);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = ent_valid[g] && (ent_page[g] == req_page);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end
  assign hit_any = |hit_vec;

  assign do_train = learn && hit_any;
  assign do_alloc = learn && !hit_any && vic_found;

  spf_victim_sel #(
    .ENTRIES (ENTRIES),
    .TIME_W  (TIME_W),
    .WARM_CYC(WARM_CYC),
    .IW      (IW)
  ) u_victim (
    .ent_valid(ent_valid),
    .ent_ts   (ent_ts),
    .ent_busy (ent_busy),
    .now      (now),
    .found    (vic_found),
    .victim   (vic_idx)
  );

  spf_stride_train #(
    .PAGE_BITS(PAGE_BITS),
    .DEGREE   (DEGREE),
    .CNT_W    (CNT_W)
  ) u_train (
    .pos        (req_pos),
    .last_pos   (ent_last[hit_idx]),
    .last2_pos  (ent_last2[hit_idx]),
    .stride     (ent_stride[hit_idx]),
    .conf       (ent_conf[hit_idx]),
    .map        (ent_map[hit_idx]),
    .free_slots (free_slots),
    .stride_next(tr_stride),
    .conf_next  (tr_conf),
    .map_next   (tr_map),
    .pf_cnt     (tr_cnt),
    .pf_pos     (tr_pos)
  );

  assign push_cnt = do_train ? tr_cnt : '0;
  for (genvar k = 0; k < DEGREE; k++) begin : g_push
    assign push_data[k] = {req_src, req_page, tr_pos[k]};
  end

  spf_pf_fifo #(
    .DEPTH   (FIFO_DEPTH),
    .W       (QW),
    .PUSH_MAX(DEGREE),
    .CNT_W   (CNT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_cnt  (push_cnt),
    .push_data (push_data),
    .out_valid (pf_valid),
    .out_ready (pf_ready),
    .out_data  (head),
    .free_slots(free_slots)
  );

  assign pf_src  = head[QW-1:LINE_W];
  assign pf_line = head[LINE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now        <= '0;
      ent_valid  <= '0;
      ent_page   <= '0;
      ent_last   <= '0;
      ent_last2  <= '0;
      ent_stride <= '0;
      ent_conf   <= '0;
      ent_map    <= '0;
      ent_ts     <= '0;
      ent_busy   <= '0;
    end else begin
      now <= now + TIME_W'(1);
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_train && hit_idx == IW'(i)) begin
          ent_last2[i]  <= ent_last[i];
          ent_last[i]   <= req_pos;
          ent_stride[i] <= tr_stride;
          ent_conf[i]   <= tr_conf;
          ent_map[i]    <= tr_map;
          ent_ts[i]     <= now;
          if (tr_cnt != '0 && $signed(fill_time - ent_busy[i]) > 0) ent_busy[i] <= fill_time;
        end else if (do_alloc && vic_idx == IW'(i)) begin
          ent_valid[i]  <= 1'b1;
          ent_page[i]   <= req_page;
          ent_last[i]   <= req_pos;
          ent_last2[i]  <= req_pos;
          ent_stride[i] <= '0;
          ent_conf[i]   <= '0;
          ent_map[i]    <= '0;
          ent_ts[i]     <= now;
          ent_busy[i]   <= now;
        end
      end
    end
  end

  assert_filtered_no_train_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !learn |=> $stable(ent_valid) && $stable(ent_page) && $stable(ent_map));

  assert_unique_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_push_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_cnt <= free_slots);

endmodule

// File: tb/stride_stream_prefetcher_bench.sv
`timescale 1ns/1ps
module stride_stream_prefetcher_bench;
  localparam int PB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_line = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_spec = 1'b0;
  logic        req_ifetch = 1'b0;
  logic [3:0]  req_src = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_line;
  logic [3:0]  pf_src;

  always #5 clk = ~clk;

  stride_stream_prefetcher #(
    .LINE_W(32), .PAGE_BITS(PB), .ENTRIES(4), .DEGREE(2),
    .FIFO_DEPTH(4), .SRC_W(4), .TIME_W(32), .WARM_CYC(500), .FILL_LAT(600)
  ) u_stride_stream_prefetcher (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_kind(req_kind), .req_spec(req_spec),
    .req_ifetch(req_ifetch), .req_src(req_src), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_line(pf_line), .pf_src(pf_src)
  );

  typedef struct {
    logic [31:0] line;
    logic [3:0]  src;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  function automatic logic [31:0] mk(int page, int pos);
    return 32'((page << PB) | pos);
  endfunction

  task automatic check(string tag, bit ok, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic send(int page, int pos, int src, logic [1:0] kind = 2'b00,
                      bit spec = 1'b0, bit ifetch = 1'b0);
    req_valid  = 1'b1;
    req_line   = mk(page, pos);
    req_kind   = kind;
    req_spec   = spec;
    req_ifetch = ifetch;
    req_src    = 4'(src);
    @(posedge clk); #1;
    req_valid  = 1'b0;
  endtask

  task automatic expect_pf(int page, int pos, int src, string tag);
    exp_t e;
    e.line = mk(page, pos);
    e.src  = 4'(src);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle(string tag);
    repeat (8) @(posedge clk);
    #1;
    check(tag, exp_q.size() == 0, "expected prefetches never produced", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R4 unexpected prefetch actual=%0h expected=none", pf_line);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (pf_line !== e.line || pf_src !== e.src) begin
          fails++;
          $display("FAIL %s prefetch actual=%0h/src%0d expected=%0h/src%0d",
                   e.tag, pf_line, pf_src, e.line, e.src);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R10", req_ready == 1'b1, "req_ready after reset", req_ready, 1);
    check("R7", pf_valid == 1'b0, "pf_valid after reset", pf_valid, 0);

    // unit stride walk: training delay, chain stop at set bit (R3 R4 R6 R2)
    for (int p = 0; p < 4; p++) send(16, p, 3);
    expect_pf(16, 5, 3, "R3");
    expect_pf(16, 6, 3, "R4");
    send(16, 4, 3);
    send(16, 5, 3);
    expect_pf(16, 7, 3, "R6");
    expect_pf(16, 8, 3, "R6");
    send(16, 6, 3);
    send(16, 7, 3);
    expect_pf(16, 9, 3, "R2");
    expect_pf(16, 10, 3, "R2");
    send(16, 8, 3);
    settle("R3");

    // filtered requests leave training untouched (R1)
    send(16, 3, 3, 2'b00, 1'b0, 1'b1);
    send(16, 3, 3, 2'b00, 1'b1, 1'b0);
    send(16, 3, 3, 2'b10);
    send(16, 3, 3, 2'b11);
    settle("R1");
    send(16, 9, 3);
    expect_pf(16, 11, 5, "R1");
    expect_pf(16, 12, 5, "R1");
    send(16, 10, 5, 2'b01);
    settle("R1");

    // negative stride and lower page edge (R5)
    send(32, 15, 1);
    send(32, 13, 1);
    send(32, 11, 1);
    send(32, 9, 1);
    expect_pf(32, 5, 1, "R5");
    expect_pf(32, 3, 1, "R5");
    send(32, 7, 1);
    send(32, 5, 1);
    expect_pf(32, 1, 1, "R5");
    send(32, 3, 1);
    settle("R5");

    // upper page edge (R5)
    for (int p = 10; p < 14; p++) send(48, p, 2);
    expect_pf(48, 15, 2, "R5");
    send(48, 14, 2);
    send(48, 15, 2);
    settle("R5");

    // full queue drops without marking (R7)
    do_reset();
    pf_ready = 1'b0;
    for (int p = 0; p < 4; p++) send(64, p, 4);
    expect_pf(64, 5, 4, "R7");
    expect_pf(64, 6, 4, "R7");
    send(64, 4, 4);
    send(64, 5, 4);
    expect_pf(64, 7, 4, "R7");
    expect_pf(64, 8, 4, "R7");
    send(64, 6, 4);
    send(64, 7, 4);
    send(64, 8, 4);
    repeat (3) @(posedge clk);
    #1;
    check("R7", pf_valid == 1'b1, "pf_valid while stalled", pf_valid, 1);
    check("R7", pf_line == mk(64, 5), "head held while stalled", pf_line, mk(64, 5));
    pf_ready = 1'b1;
    settle("R7");
    expect_pf(64, 10, 4, "R7");
    expect_pf(64, 11, 4, "R7");
    send(64, 9, 4);
    settle("R7");

    // least recently used replacement (R8)
    do_reset();
    for (int pg = 80; pg < 84; pg++) send(pg, 0, 7);
    send(81, 1, 7);
    send(82, 1, 7);
    send(83, 1, 7);
    send(80, 1, 7);
    send(84, 0, 7);
    send(80, 2, 7);
    send(80, 3, 7);
    expect_pf(80, 5, 7, "R8");
    expect_pf(80, 6, 7, "R8");
    send(80, 4, 7);
    send(81, 2, 7);
    send(81, 3, 7);
    send(81, 4, 7);
    settle("R8");

    // recently prefetching entry survives replacement (R9)
    do_reset();
    for (int p = 0; p < 4; p++) send(96, p, 6);
    expect_pf(96, 5, 6, "R9");
    expect_pf(96, 6, 6, "R9");
    send(96, 4, 6);
    send(97, 0, 6);
    send(98, 0, 6);
    send(99, 0, 6);
    send(100, 0, 6);
    send(96, 5, 6);
    expect_pf(96, 7, 6, "R9");
    expect_pf(96, 8, 6, "R9");
    send(96, 6, 6);
    settle("R9");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule